// File: doc/BRIEF.md
# Synchronized External Edge Down-Counter

This block counts rising edges of an external signal that has no fixed relation to the system clock. The signal first passes through a three-flop resynchronizer, then an edge detector. Each rising edge that arrives while counting is enabled takes one off a down-counter. The counter starts from all ones and wraps back to all ones after it reaches zero.

Software reads the current count over a small word-addressed register bus. The block has three registers:

| Word address | Register | Access |
|---|---|---|
| 0 | count | read only |
| 1 | clear | write only, reads 0 |
| 2 | control | bit 0 is the count enable |

A plain write cannot clear the counter. The clear register acts only when a guarded key value, 0x55AA, lands in a fully byte-enabled 16-bit half of the data word. The counter width is the parameter `CNT_W`, 32 by default. Reads return the count zero-extended to 32 bits.

Top module: `ext_edge_downcounter`

## Requirements
- R1: The external input passes through three flip-flop stages and then an edge detector. A rising level driven before clock edge k is first visible as a decremented count after clock edge k+3, and not yet after edge k+2.
- R2: Each rising edge of the synchronized input decrements the count by exactly one. A level held high for many clocks gives no further decrement, and falling edges do not decrement.
- R3: While control bit 0 is 0, edges do not change the count. Edges that arrive during that time are not counted later.
- R4: A read of word address 0 returns the current count, zero-extended to 32 bits.
- R5: After reset the count is all ones. A decrement from zero gives all ones.
- R6: A write to word address 1 clears the count to all ones in two cases. The first is a write with byte enables 4'b0011 and bus_wdata[15:0] = 0x55AA. The second is a write with byte enables 4'b1100 and bus_wdata[31:16] = 0x55AA.
- R7: A 32-bit write to word address 1 (byte enables 4'b1111) clears the count when either 16-bit half holds 0x55AA.
- R8: A write to word address 1 leaves the count unchanged in any of these cases:
  - neither fully enabled half holds 0x55AA;
  - the half that holds 0x55AA is only partly byte-enabled;
  - the key sits in a half whose bytes are not enabled.
- R9: A read of word address 1 always returns 0x00000000.
- R10: Control bit 0 resets to 0. It is written through byte enable bit 0 at word address 2 and reads back at that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_in | input | 1 | External asynchronous signal whose rising edges are counted |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | 2 | Word address: 0 count, 1 clear, 2 control |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte enables for the write |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |

## Verification
The input is driven in three patterns:
- Short isolated high pulses measure the decrement per edge.
- A level held high for many clocks separates edge detection from level counting.
- Pulses sent while counting is disabled show that the enable gate drops edges rather than deferring them.

The input is also sampled one cycle either side of the expected update, which pins the synchronizer depth at exactly three stages. Clear writes cover the key in the low half, in the high half, in a full word with either half, off by one bit, in a partly enabled half, and in a half that is not enabled. Together these separate the key compare from the byte-enable handling. Finally, the bench runs a full lap with the counter narrowed to 8 bits, which exposes the wrap from zero.

// File: rtl/edge_cnt_pkg.sv
package edge_cnt_pkg;

    localparam int BUS_W       = 32;
    localparam int BE_W        = BUS_W / 8;
    localparam int HALF_W      = BUS_W / 2;
    localparam int SYNC_DEPTH  = 3;
    localparam logic [HALF_W-1:0] CLEAR_KEY = 16'h55AA;

    typedef enum logic [1:0] {
        REG_COUNT = 2'd0,
        REG_CLEAR = 2'd1,
        REG_CTRL  = 2'd2,
        REG_NONE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              we;
        reg_sel_e          sel;
        logic [BUS_W-1:0]  wdata;
        logic [BE_W-1:0]   be;
    } bus_req_t;

    // A half counts only if both of its bytes are enabled and it holds the key.
    function automatic logic key_hit(input logic [BUS_W-1:0] d,
                                     input logic [BE_W-1:0]  be);
        logic lo_ok;
        logic hi_ok;
        lo_ok = (be[1:0] == 2'b11) && (d[HALF_W-1:0] == CLEAR_KEY);
        hi_ok = (be[3:2] == 2'b11) && (d[BUS_W-1:HALF_W] == CLEAR_KEY);
        return lo_ok || hi_ok;
    endfunction

endpackage

// File: rtl/edge_cnt_sync.sv
module edge_cnt_sync #(
    parameter int STAGES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b0;
                    else     chain_q[0] <= async_i;
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (rst) chain_q[g] <= 1'b0;
                    else     chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/edge_cnt_rise.sv
module edge_cnt_rise (
    input  logic clk,
    input  logic rst,
    input  logic level_i,
    output logic rise_o
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= level_i;
    end

    assign rise_o = level_i & ~prev_q;

    // R2: a rising edge needs a low cycle in between, so pulses never abut
    property rise_isolated_p;
        @(posedge clk) disable iff (rst) rise_o |=> !rise_o;
    endproperty
    single_pulse_chk: assert property (rise_isolated_p);

endmodule

// File: rtl/edge_cnt_regs.sv
module edge_cnt_regs
    import edge_cnt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          req_i,
    input  logic [CNT_W-1:0]  count_i,
    output logic [BUS_W-1:0]  rdata_o,
    output logic              clear_o,
    output logic              enable_o
);
    logic en_q;

    always_ff @(posedge clk) begin
        if (rst)
            en_q <= 1'b0;
        else if (req_i.we && req_i.sel == REG_CTRL && req_i.be[0])
            en_q <= req_i.wdata[0];
    end

    assign clear_o  = req_i.we && (req_i.sel == REG_CLEAR) && key_hit(req_i.wdata, req_i.be);
    assign enable_o = en_q;

    always_comb begin
        unique case (req_i.sel)
            REG_COUNT: rdata_o = BUS_W'(count_i);
            REG_CTRL:  rdata_o = BUS_W'(en_q);
            default:   rdata_o = '0;
        endcase
    end

    // R8: a clear request only ever comes from a write to the clear register
    property clear_source_p;
        @(posedge clk) disable iff (rst) clear_o |-> (req_i.we && req_i.sel == REG_CLEAR);
    endproperty
    clear_only_on_write_chk: assert property (clear_source_p);

    // R10: the enable holds its value unless the control register is written
    property enable_hold_p;
        @(posedge clk) disable iff (rst)
            !(req_i.we && req_i.sel == REG_CTRL) |=> $stable(en_q);
    endproperty
    enable_hold_chk: assert property (enable_hold_p);

endmodule

// File: rtl/edge_cnt_core.sv
module edge_cnt_core #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rise_i,
    input  logic             enable_i,
    input  logic             clear_i,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] ALL_ONES = '1;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear_i)
            cnt_q <= ALL_ONES;
        else if (rise_i && enable_i)
            cnt_q <= cnt_q - 1'b1;
    end

    assign count_o = cnt_q;

    // R5: stepping down from zero lands on all ones
    property wrap_p;
        @(posedge clk) disable iff (rst)
            (rise_i && enable_i && !clear_i && cnt_q == '0) |=> (cnt_q == ALL_ONES);
    endproperty
    wrap_to_ones_chk: assert property (wrap_p);

    // R3: without a gated edge or a clear the count does not move
    property hold_p;
        @(posedge clk) disable iff (rst)
            (!(rise_i && enable_i) && !clear_i) |=> $stable(cnt_q);
    endproperty
    count_hold_chk: assert property (hold_p);

    // R2: a gated edge lowers the count by exactly one
    property step_p;
        @(posedge clk) disable iff (rst)
            (rise_i && enable_i && !clear_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1);
    endproperty
    step_one_chk: assert property (step_p);

    // R6: a clear always leaves all ones behind
    property clear_p;
        @(posedge clk) disable iff (rst) clear_i |=> (cnt_q == ALL_ONES);
    endproperty
    clear_sets_ones_chk: assert property (clear_p);

endmodule

// File: rtl/ext_edge_downcounter.sv
module ext_edge_downcounter
    import edge_cnt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_in,
    input  logic              bus_we,
    input  logic [1:0]        bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic [BE_W-1:0]   bus_be,
    output logic [BUS_W-1:0]  bus_rdata
);
    logic             sync_lvl;
    logic             rise;
    logic             clear;
    logic             enable;
    logic [CNT_W-1:0] count;
    bus_req_t         req;

    assign req.we    = bus_we;
    assign req.sel   = reg_sel_e'(bus_addr);
    assign req.wdata = bus_wdata;
    assign req.be    = bus_be;

    edge_cnt_sync #(.STAGES(SYNC_DEPTH)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (ext_in),
        .sync_o  (sync_lvl)
    );

    edge_cnt_rise u_rise (
        .clk     (clk),
        .rst     (rst),
        .level_i (sync_lvl),
        .rise_o  (rise)
    );

    edge_cnt_regs #(.CNT_W(CNT_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .req_i    (req),
        .count_i  (count),
        .rdata_o  (bus_rdata),
        .clear_o  (clear),
        .enable_o (enable)
    );

    edge_cnt_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .rise_i   (rise),
        .enable_i (enable),
        .clear_i  (clear),
        .count_o  (count)
    );

endmodule

// File: tb/ext_edge_downcounter_tb.sv
module ext_edge_downcounter_tb_top;

    localparam int TB_W = 8;
    localparam logic [31:0] TOP = 32'h0000_00FF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ext_in = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    ext_edge_downcounter #(.CNT_W(TB_W)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .ext_in    (ext_in),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_be    (bus_be),
        .bus_rdata (bus_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_we = 1'b0; bus_be = '0; bus_wdata = '0;
    endtask

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ext_in = 1'b1;
            repeat (5) @(negedge clk);
            ext_in = 1'b0;
            repeat (5) @(negedge clk);
        end
    endtask

    task automatic expect_count(input string req, input logic [31:0] exp);
        logic [31:0] d;
        rd(2'd0, d);
        check(req, d, exp);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        expect_count("R5 reset count", TOP);
        rd(2'd2, d); check("R10 reset enable", d, 32'd0);
        rd(2'd1, d); check("R9 clear reads zero", d, 32'd0);
    endtask

    task automatic t_disabled;
        pulse(3);
        expect_count("R3 disabled edges ignored", TOP);
    endtask

    task automatic t_enable;
        logic [31:0] d;
        wr(2'd2, 32'h1, 4'b0001);
        rd(2'd2, d); check("R10 enable readback", d, 32'd1);
        expect_count("R3 no late count of lost edges", TOP);
    endtask

    task automatic t_latency;
        logic [31:0] d;
        @(negedge clk); ext_in = 1'b1; bus_addr = 2'd0;
        repeat (3) @(posedge clk);
        @(negedge clk); #1 d = bus_rdata;
        check("R1 not yet after third edge", d, TOP);
        @(posedge clk);
        @(negedge clk); #1 d = bus_rdata;
        check("R1 decrement after fourth edge", d, TOP - 1);
        repeat (20) @(negedge clk);
        expect_count("R2 held level counts once", TOP - 1);
        ext_in = 1'b0;
        repeat (10) @(negedge clk);
        expect_count("R2 falling edge ignored", TOP - 1);
        pulse(4);
        expect_count("R4 count after four more edges", TOP - 5);
    endtask

    task automatic t_clear16;
        wr(2'd1, 32'h0000_55AA, 4'b0011);
        expect_count("R6 low half key clears", TOP);
        pulse(2);
        expect_count("R2 two edges", TOP - 2);
        wr(2'd1, 32'h55AA_0000, 4'b1100);
        expect_count("R6 high half key clears", TOP);
    endtask

    task automatic t_clear32;
        pulse(1);
        wr(2'd1, 32'h1234_55AA, 4'b1111);
        expect_count("R7 word write key low clears", TOP);
        pulse(3);
        wr(2'd1, 32'h55AA_9876, 4'b1111);
        expect_count("R7 word write key high clears", TOP);
    endtask

    task automatic t_nokey;
        logic [31:0] d;
        pulse(3);
        wr(2'd1, 32'h0000_55AB, 4'b0011);
        wr(2'd1, 32'h0000_55AA, 4'b0001);
        wr(2'd1, 32'h0000_55AA, 4'b1100);
        wr(2'd1, 32'hAA55_AA55, 4'b1111);
        wr(2'd0, 32'h0000_55AA, 4'b1111);
        expect_count("R8 non-key writes no effect", TOP - 3);
        rd(2'd1, d); check("R9 clear reads zero after writes", d, 32'd0);
    endtask

    task automatic t_disable_mid;
        wr(2'd2, 32'h0, 4'b0001);
        pulse(2);
        expect_count("R3 disabled mid-run", TOP - 3);
        wr(2'd2, 32'h1, 4'b0001);
        pulse(1);
        expect_count("R3 re-enabled counts again", TOP - 4);
    endtask

    task automatic t_wrap;
        wr(2'd1, 32'h0000_55AA, 4'b0011);
        pulse(255);
        expect_count("R5 reaches zero", 32'd0);
        pulse(1);
        expect_count("R5 wraps to all ones", TOP);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_disabled();
        t_enable();
        t_latency();
        t_clear16();
        t_clear32();
        t_nokey();
        t_disable_mid();
        t_wrap();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule